// File: doc/BRIEF.md
# Biphase Data Line Decoder

This block recovers the payload of one dedicated data line in the vertical blanking interval of a video signal. The timing logic raises `line_active` for the data part of line 16 of each field, and the slicer feeds one sliced data sample per clock through `sample_bit`. The 10 MHz decoder timebase gives a nominal `SPH` samples per half-bit. Each half-bit is decided by a majority vote over its samples, and two half-bits form one biphase cell.

Every cell is checked for a legal biphase pattern. The first `SYNC_BITS` cells must reproduce a fixed run-in and start word. The next `NBYTES` bytes are collected in an internal buffer. When the window closes, the block commits all bytes at once, and only if the whole line was clean. A single violation anywhere, even in the last byte, discards the line.

A committed line appears as one wide word on a valid/ready output. `out_valid` rises and stays high, with `out_data` frozen, until a cycle with `out_ready` high. Back-pressure never stalls decoding, because a line cannot be paused. A clean line that completes while an earlier one is still unaccepted is dropped, unless `out_ready` is high in that same cycle. The active-low flag `dav_n` falls on every commit.

Top module: `bpd_line_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `dav_n` is 1.
- R2: A half-bit is 1 when more than half of its `SPH` samples are 1, and 0 when fewer than half are 1. An exact tie is a biphase error: with `SPH`=2, two differing samples are an error.
- R3: A cell whose halves are (1,0) decodes to 1, and a cell whose halves are (0,1) decodes to 0. Equal halves are a biphase error.
- R4: The first `SYNC_BITS` decoded bits must equal `SYNC_WORD`, most significant bit first. Any mismatch drops the line.
- R5: After the sync word, data bits arrive most significant bit first. Byte k of the line appears at `out_data[8k+7:8k]`.
- R6: A biphase error in any sync or data cell drops the whole line, including the bytes already received.
- R7: A window that closes before all `NBYTES` bytes have been received drops the line.
- R8: Cells that follow the last data bit are ignored up to the close of the window, and errors among them do not drop the line.
- R9: For a clean line, `out_valid` rises and `dav_n` falls on the third rising clock edge at which `line_active` is low, and not before.
- R10: `dav_n` returns to 1 after the first rising edge of a new window at which `line_active` is high.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds. A clean line that completes in such a cycle is discarded. If `out_ready` is high in that cycle, the new line replaces the accepted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_active | input | 1 | Data window of the dedicated line |
| sample_bit | input | 1 | Sliced data sample |
| out_ready | input | 1 | Consumer accepts the committed line |
| out_valid | output | 1 | Committed line available |
| out_data | output | NBYTES*8 | Line bytes, byte 0 in the low bits |
| dav_n | output | 1 | Active-low data-valid flag |

## Verification
The bench builds the decoder with `NBYTES`=3, `SPH`=2 and an 8-bit sync word of 0xAB. That gives a 32-cell line, so random lines can place errors, truncations and trailing cells at every cell position in a short run. With two samples per half-bit, a tie is easy to provoke from the bench, so R2's tie rule is checked directly. The small byte count also keeps each line short enough to test the back-pressure and same-cycle acceptance paths of R11 by hand.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic [1:0] {
    ASM_SYNC,
    ASM_DATA,
    ASM_DONE,
    ASM_DROP
  } asm_state_e;
endpackage

// File: rtl/bpd_halfbit_vote.sv
module bpd_halfbit_vote #(
  parameter int SPH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_active,
  input  logic sample_bit,
  output logic hb_stb,
  output logic hb_val,
  output logic hb_tie,
  output logic end_stb
);
  localparam int CW = $clog2(SPH + 1);
  localparam logic [CW+1:0] SPH_W = (CW + 2)'(SPH);

  logic [CW-1:0] cnt, ones;
  logic [CW:0]   ones_n;
  logic [CW+1:0] dbl;
  logic          act_q;

  always_comb begin
    ones_n = {1'b0, ones} + (CW + 1)'(sample_bit);
    dbl    = {ones_n, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ones <= '0; act_q <= 1'b0;
      hb_stb <= 1'b0; hb_val <= 1'b0; hb_tie <= 1'b0; end_stb <= 1'b0;
    end else begin
      act_q   <= line_active;
      hb_stb  <= 1'b0;
      end_stb <= 1'b0;
      if (line_active) begin
        if (cnt == CW'(SPH - 1)) begin
          hb_stb <= 1'b1;
          hb_val <= dbl > SPH_W;
          hb_tie <= dbl == SPH_W;
          cnt    <= '0;
          ones   <= '0;
        end else begin
          cnt  <= cnt + 1'b1;
          ones <= ones_n[CW-1:0];
        end
      end else begin
        cnt  <= '0;
        ones <= '0;
        if (act_q) end_stb <= 1'b1;
      end
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    hb_stb |-> !end_stb); // R9
  AST_VOTE_DECIDED: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_stb && hb_tie) |-> !hb_val); // R2
endmodule

// File: rtl/bpd_cell_pair.sv
module bpd_cell_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_stb,
  input  logic hb_val,
  input  logic hb_tie,
  input  logic end_in,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_err,
  output logic end_out
);
  logic phase, first_val, first_tie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0; first_val <= 1'b0; first_tie <= 1'b0;
      bit_stb <= 1'b0; bit_val <= 1'b0; bit_err <= 1'b0; end_out <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      end_out <= end_in;
      if (end_in) begin
        phase <= 1'b0;
      end else if (hb_stb) begin
        if (!phase) begin
          phase     <= 1'b1;
          first_val <= hb_val;
          first_tie <= hb_tie;
        end else begin
          phase   <= 1'b0;
          bit_stb <= 1'b1;
          bit_val <= first_val;
          bit_err <= first_tie | hb_tie | (first_val == hb_val);
        end
      end
    end
  end

  AST_BIT_AFTER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |-> $past(hb_stb)); // R3
  AST_END_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    end_out |-> !bit_stb); // R9
endmodule

// File: rtl/bpd_line_asm.sv
module bpd_line_asm
  import bpd_pkg::*;
#(
  parameter int NBYTES = 13,
  parameter int SYNC_BITS = 8,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 8'hAB
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  line_active,
  input  logic                  bit_stb,
  input  logic                  bit_val,
  input  logic                  bit_err,
  input  logic                  end_stb,
  input  logic                  out_ready,
  output logic                  out_valid,
  output logic [NBYTES*8-1:0]   out_data,
  output logic                  dav_n
);
  localparam int DBITS = NBYTES * 8;
  localparam int CNTW  = $clog2(DBITS + SYNC_BITS);
  localparam int IW    = $clog2(DBITS);

  asm_state_e           state;
  logic [CNTW-1:0]      cnt;
  logic [IW-1:0]        idx;
  logic [SYNC_BITS-1:0] sync_sh;
  logic [DBITS-1:0]     buf_q;
  logic                 act_q;

  always_comb idx = IW'({cnt[CNTW-1:3], ~cnt[2:0]});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ASM_SYNC; cnt <= '0; sync_sh <= SYNC_WORD; buf_q <= '0;
      act_q <= 1'b0; out_valid <= 1'b0; out_data <= '0; dav_n <= 1'b1;
    end else begin
      act_q <= line_active;
      if (line_active && !act_q) dav_n <= 1'b1;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (end_stb) begin
        if (state == ASM_DONE && (!out_valid || out_ready)) begin
          out_valid <= 1'b1;
          out_data  <= buf_q;
          dav_n     <= 1'b0;
        end
        state   <= ASM_SYNC;
        cnt     <= '0;
        sync_sh <= SYNC_WORD;
      end else if (bit_stb) begin
        case (state)
          ASM_SYNC: begin
            if (bit_err || bit_val != sync_sh[SYNC_BITS-1]) begin
              state <= ASM_DROP;
            end else if (cnt == CNTW'(SYNC_BITS - 1)) begin
              state <= ASM_DATA;
              cnt   <= '0;
            end else begin
              cnt     <= cnt + 1'b1;
              sync_sh <= sync_sh << 1;
            end
          end
          ASM_DATA: begin
            if (bit_err) begin
              state <= ASM_DROP;
            end else begin
              buf_q[idx] <= bit_val;
              if (cnt == CNTW'(DBITS - 1)) state <= ASM_DONE;
              else cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11
  AST_DAV_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_n) |-> out_valid); // R9
  AST_COMMIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(state) == ASM_DONE); // R6
  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ASM_DROP && !end_stb) |=> state == ASM_DROP); // R6
endmodule

// File: rtl/bpd_line_decoder.sv
module bpd_line_decoder #(
  parameter int SPH = 2,
  parameter int NBYTES = 13,
  parameter int SYNC_BITS = 8,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = 8'hAB
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_active,
  input  logic                sample_bit,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [NBYTES*8-1:0] out_data,
  output logic                dav_n
);
  logic hb_stb, hb_val, hb_tie, end1;
  logic bit_stb, bit_val, bit_err, end2;

  bpd_halfbit_vote #(.SPH(SPH)) u_vote (
    .clk(clk), .rst_n(rst_n), .line_active(line_active), .sample_bit(sample_bit),
    .hb_stb(hb_stb), .hb_val(hb_val), .hb_tie(hb_tie), .end_stb(end1)
  );

  bpd_cell_pair u_pair (
    .clk(clk), .rst_n(rst_n), .hb_stb(hb_stb), .hb_val(hb_val), .hb_tie(hb_tie),
    .end_in(end1), .bit_stb(bit_stb), .bit_val(bit_val), .bit_err(bit_err),
    .end_out(end2)
  );

  bpd_line_asm #(.NBYTES(NBYTES), .SYNC_BITS(SYNC_BITS), .SYNC_WORD(SYNC_WORD)) u_asm (
    .clk(clk), .rst_n(rst_n), .line_active(line_active), .bit_stb(bit_stb),
    .bit_val(bit_val), .bit_err(bit_err), .end_stb(end2), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .dav_n(dav_n)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && dav_n)); // R1
endmodule

// File: tb/tb_bpd_line_decoder.sv
`timescale 1ns/1ps
module tb_bpd_line_decoder;
  localparam int SPH = 2;
  localparam int NB = 3;
  localparam int SB = 8;
  localparam logic [SB-1:0] SW = 8'hAB;
  localparam int NCELL = SB + NB * 8;

  logic clk = 1'b0, rst_n = 1'b0, line_active = 1'b0, sample_bit = 1'b0, out_ready = 1'b0;
  logic out_valid, dav_n;
  logic [NB*8-1:0] out_data;
  int n_chk = 0, n_bad = 0;
  bit first_smp;

  always #2.5 clk = ~clk;

  bpd_line_decoder #(.SPH(SPH), .NBYTES(NB), .SYNC_BITS(SB), .SYNC_WORD(SW)) dut (
    .clk(clk), .rst_n(rst_n), .line_active(line_active), .sample_bit(sample_bit),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .dav_n(dav_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic cell_bit(input logic [NB*8-1:0] d, input int i);
    int j;
    if (i < SB) return SW[SB-1-i];
    j = i - SB;
    if (j >= NB * 8) return 1'b0;
    return d[(j / 8) * 8 + 7 - (j % 8)];
  endfunction

  task automatic drive(input logic v);
    line_active = 1'b1;
    sample_bit  = v;
    @(negedge clk);
    if (first_smp) begin
      chk(dav_n == 1'b1, "R10 dav_n high at window start", 32'(dav_n), 1);
      first_smp = 1'b0;
    end
  endtask

  task automatic half(input logic v, input bit tie);
    for (int s = 0; s < SPH; s++) drive(tie ? logic'(s < SPH / 2) : v);
  endtask

  // mode: 0 clean, 1 equal halves at pos, 2 tie half at pos, 3 sync flip at pos,
  //       4 window closes after pos cells, 5 pos illegal cells after the data
  task automatic run_line(input logic [NB*8-1:0] d, input int mode, input int pos, input bit rdy);
    int ncell;
    logic pre_v;
    ncell = (mode == 4) ? pos : ((mode == 5) ? NCELL + pos : NCELL);
    pre_v = out_valid;
    first_smp = 1'b1;
    for (int i = 0; i < ncell; i++) begin
      logic b, h0, h1;
      b = cell_bit(d, i);
      h0 = b; h1 = ~b;
      if (mode == 3 && i == pos) begin h0 = ~b; h1 = b; end
      if (mode == 1 && i == pos) h1 = h0;
      if (mode == 5 && i >= NCELL) h1 = h0;
      half(h0, mode == 2 && i == pos);
      half(h1, 1'b0);
    end
    line_active = 1'b0;
    sample_bit  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (!rdy) chk(out_valid == pre_v, "R9 no commit before third low edge", 32'(out_valid), 32'(pre_v));
    if (rdy) out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic expect_line(input bit good, input logic [NB*8-1:0] d, input string req);
    chk(out_valid == good, req, 32'(out_valid), 32'(good));
    chk(dav_n == !good, req, 32'(dav_n), 32'(!good));
    if (good) chk(out_data == d, req, 32'(out_data), 32'(d));
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [NB*8-1:0] a;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && dav_n == 1'b1, "R1 reset state", {30'd0, out_valid, dav_n}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && dav_n == 1'b1, "R1 after release", {30'd0, out_valid, dav_n}, 32'h1);

    run_line(24'hC35A01, 0, 0, 0);
    expect_line(1, 24'hC35A01, "R5 R9 clean line byte order");
    accept();
    run_line(24'h0F1E2D, 1, NCELL - 1, 0);
    expect_line(0, '0, "R6 late error in last data cell");
    run_line(24'h123456, 1, 2, 0);
    expect_line(0, '0, "R6 R3 equal halves in sync");
    run_line(24'hFFFFFF, 2, 10, 0);
    expect_line(0, '0, "R2 tied half-bit");
    run_line(24'h00FF00, 3, 3, 0);
    expect_line(0, '0, "R4 sync word mismatch");
    run_line(24'hA5A5A5, 4, 20, 0);
    expect_line(0, '0, "R7 short window");
    run_line(24'hA5A5A5, 4, SB, 0);
    expect_line(0, '0, "R7 window closes after sync only");
    run_line(24'h5AA55A, 5, 3, 0);
    expect_line(1, 24'h5AA55A, "R8 trailing illegal cells ignored");

    // back-pressure: pending line not overwritten
    run_line(24'h111111, 0, 0, 0);
    chk(out_data == 24'h5AA55A, "R11 held data kept", 32'(out_data), 32'h5AA55A);
    chk(out_valid == 1'b1, "R11 valid held", 32'(out_valid), 1);
    run_line(24'h777777, 0, 0, 1);
    expect_line(1, 24'h777777, "R11 replace on same-cycle accept");
    accept();

    for (int n = 0; n < 60; n++) begin
      int m, p;
      a = 24'($urandom);
      m = $urandom_range(0, 5);
      case (m)
        1, 2: p = $urandom_range(0, NCELL - 1);
        3: p = $urandom_range(0, SB - 1);
        4: p = $urandom_range(1, NCELL - 1);
        5: p = $urandom_range(1, 4);
        default: p = 0;
      endcase
      run_line(a, m, p, 0);
      expect_line(m == 0 || m == 5, a, "R3 R5 R6 random line");
      accept();
      repeat (2) @(negedge clk);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule